// File: doc/BRIEF.md
# Beam Crossing History Capture

This block watches a small vector of trigger state bits and keeps a short history of it, one entry per crossing tick. A qualifying strobe (`tick`) marks each crossing, and only those cycles move the history forward. The state is run through a fixed pipeline delay before it enters the history. That delay lets the block sit downstream of other trigger stages and still line up each stored entry with the crossing it belongs to.

An accept pulse names a triggered crossing. The block then collects a window around that crossing: `PREV` crossings before it, the triggered crossing itself, and `NEXT` crossings after it. Because later crossings have to arrive first, the window closes some ticks after the accept. The window is then frozen and offered as 16-bit words, and the reader steps through them with a request strobe.

The default set-up holds four state bits over four crossings (one before, three from the trigger onward), which makes one word. A wide variant, for example 32 bits with three previous crossings and none after, gives eight words from the same logic. Only one window is held at a time. An accept that comes while a window is still being built or is still unread is reported and otherwise dropped.

Top module: `xing_history_capture`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `rd_valid`, `rd_last` and `rd_overrun` are 0 and `rd_data` is 0.
- R2: Only cycles with `tick` high are crossings. `state_in` and `accept` are ignored in any cycle with `tick` low, so an accept without a tick never produces a window.
- R3: An accept given with the tick of crossing c closes its window at the clock edge of crossing c+LAT+NEXT. `rd_valid` is high from the cycle after that edge.
- R4: The frozen window holds the `state_in` values of crossings c-PREV through c+NEXT. Any crossing before the first tick after reset counts as all zeros.
- R5: The window is packed by crossing. Bits [j*NBITS +: NBITS] hold crossing c-PREV+j, so the oldest crossing sits in the lowest bits. Word w is bits [16w+15:16w], and any bits above the window are zero.
- R6: While `rd_valid` is high, `rd_data` shows the current word, starting at word 0. Each `rd_req` moves to the next word. `rd_last` is high on the final word. An `rd_req` on the final word drops `rd_valid` in the next cycle. `rd_req` has no effect while `rd_valid` is low.
- R7: An accept is rejected if its delayed turn arrives while a window is being built or is held and unread. In that case `rd_overrun` is high for exactly the cycle after that tick's edge, no new window starts, and the held words do not change.
- R8: `rd_data` is 0 whenever `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Crossing strobe; history advances only on these cycles |
| state_in | input | NBITS | Trigger state bits of the current crossing |
| accept | input | 1 | Names the current crossing as triggered (valid with `tick`) |
| rd_req | input | 1 | Advance to the next readout word |
| rd_data | output | 16 | Current word of the frozen window |
| rd_valid | output | 1 | A frozen window is available |
| rd_last | output | 1 | `rd_data` is the final word of the window |
| rd_overrun | output | 1 | One-cycle flag for a rejected accept |

## Verification
Some behaviour is checked by assertions on every cycle:
- the quiet state after reset;
- `rd_data` reading zero while nothing is held;
- a window appearing only on a tick edge;
- held words staying still when no request arrives;
- the overrun flag following only a tick edge;
- `rd_valid` dropping after the final word is read.

Other behaviour can only be shown by the bench's scenarios, because it depends on the history of inputs: the contents and packing order of the window, the delay from accept to freeze, and zero-filling of crossings before the first tick. The bench runs a behavioural model in parallel to check these, through directed sequences (an early accept, sparse ticks, back-to-back accepts, an accept without a tick) and a long random run.

// File: rtl/xhc_pkg.sv
package xhc_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,
        CAP_WAIT = 2'd1,
        CAP_HELD = 2'd2
    } cap_state_e;

    function automatic int words_for(input int bits);
        return (bits + WORD_W - 1) / WORD_W;
    endfunction

    function automatic int count_width(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/xhc_delay.sv
module xhc_delay #(
    parameter int W   = 5,
    parameter int LAT = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (LAT == 0) begin : g_pass
            assign q = d;
        end else begin : g_pipe
            logic [W-1:0] stg [LAT];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < LAT; i++) stg[i] <= '0;
                end else if (en) begin
                    stg[0] <= d;
                    for (int i = 1; i < LAT; i++) stg[i] <= stg[i-1];
                end
            end
            assign q = stg[LAT-1];
        end
    endgenerate
endmodule

// File: rtl/xhc_window.sv
module xhc_window #(
    parameter int NBITS = 4,
    parameter int PREV  = 1,
    parameter int NEXT  = 2
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             tick,
    input  logic [NBITS-1:0]                 din,
    output logic [(PREV+1+NEXT)*NBITS-1:0]   win
);
    localparam int WIN   = PREV + 1 + NEXT;
    localparam int DEPTH = WIN - 1;

    generate
        if (DEPTH == 0) begin : g_single
            assign win = din;
        end else begin : g_hist
            // hist[0] is the most recent stored crossing
            logic [NBITS-1:0] hist [DEPTH];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
                end else if (tick) begin
                    hist[0] <= din;
                    for (int i = 1; i < DEPTH; i++) hist[i] <= hist[i-1];
                end
            end
            // slot 0 = oldest crossing, slot WIN-1 = crossing entering now
            for (genvar j = 0; j < WIN; j++) begin : g_slot
                if (j == WIN - 1) begin : g_new
                    assign win[j*NBITS +: NBITS] = din;
                end else begin : g_old
                    assign win[j*NBITS +: NBITS] = hist[WIN-2-j];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/xhc_ctrl.sv
module xhc_ctrl
    import xhc_pkg::*;
#(
    parameter int NEXT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic acc_h,
    input  logic rd_done,
    output logic cap,
    output logic held,
    output logic ovr
);
    localparam int CW = count_width(NEXT);

    cap_state_e    state_q;
    logic [CW-1:0] left_q;
    logic          acc_t;

    assign acc_t = tick & acc_h;
    assign held  = (state_q == CAP_HELD);

    always_comb begin
        cap = 1'b0;
        if (tick) begin
            if (state_q == CAP_IDLE && acc_t && NEXT == 0) cap = 1'b1;
            if (state_q == CAP_WAIT && left_q == CW'(1))   cap = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CAP_IDLE;
            left_q  <= '0;
            ovr     <= 1'b0;
        end else begin
            ovr <= acc_t && (state_q != CAP_IDLE);
            case (state_q)
                CAP_IDLE: begin
                    if (acc_t) begin
                        if (NEXT == 0) begin
                            state_q <= CAP_HELD;
                        end else begin
                            state_q <= CAP_WAIT;
                            left_q  <= CW'(NEXT);
                        end
                    end
                end
                CAP_WAIT: begin
                    if (tick) begin
                        if (left_q == CW'(1)) state_q <= CAP_HELD;
                        else                  left_q  <= left_q - 1'b1;
                    end
                end
                CAP_HELD: begin
                    if (rd_done) state_q <= CAP_IDLE;
                end
                default: state_q <= CAP_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xhc_readout.sv
module xhc_readout
    import xhc_pkg::*;
#(
    parameter int REC_BITS = 16,
    parameter int NWORDS   = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cap,
    input  logic [REC_BITS-1:0] rec_in,
    input  logic                held,
    input  logic                rd_req,
    output logic [WORD_W-1:0]   rd_data,
    output logic                rd_last,
    output logic                rd_done
);
    localparam int PB = NWORDS * WORD_W;
    localparam int IW = (NWORDS < 2) ? 1 : $clog2(NWORDS);

    logic [PB-1:0] rec_q;
    logic [IW-1:0] idx_q;

    assign rd_last = held && (idx_q == IW'(NWORDS - 1));
    assign rd_done = held && rd_req && rd_last;
    assign rd_data = held ? rec_q[32'(idx_q)*WORD_W +: WORD_W] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q <= '0;
            idx_q <= '0;
        end else if (cap) begin
            rec_q <= PB'(rec_in);
            idx_q <= '0;
        end else if (held && rd_req) begin
            idx_q <= rd_last ? '0 : idx_q + 1'b1;
        end
    end
endmodule

// File: rtl/xing_history_capture.sv
module xing_history_capture
    import xhc_pkg::*;
#(
    parameter int NBITS = 4,
    parameter int PREV  = 1,
    parameter int NEXT  = 2,
    parameter int LAT   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [NBITS-1:0] state_in,
    input  logic             accept,
    input  logic             rd_req,
    output logic [15:0]      rd_data,
    output logic             rd_valid,
    output logic             rd_last,
    output logic             rd_overrun
);
    localparam int WIN      = PREV + 1 + NEXT;
    localparam int REC_BITS = WIN * NBITS;
    localparam int NWORDS   = words_for(REC_BITS);

    logic [NBITS:0]      dly_q;
    logic [NBITS-1:0]    state_d;
    logic                acc_d;
    logic [REC_BITS-1:0] win;
    logic                cap, rd_done;

    // accept travels with its state so both keep the same alignment
    xhc_delay #(.W(NBITS + 1), .LAT(LAT)) u_delay (
        .clk(clk), .rst(rst), .en(tick),
        .d({accept, state_in}), .q(dly_q)
    );
    assign state_d = dly_q[NBITS-1:0];
    assign acc_d   = dly_q[NBITS];

    xhc_window #(.NBITS(NBITS), .PREV(PREV), .NEXT(NEXT)) u_window (
        .clk(clk), .rst(rst), .tick(tick), .din(state_d), .win(win)
    );

    xhc_ctrl #(.NEXT(NEXT)) u_ctrl (
        .clk(clk), .rst(rst), .tick(tick), .acc_h(acc_d),
        .rd_done(rd_done), .cap(cap), .held(rd_valid), .ovr(rd_overrun)
    );

    xhc_readout #(.REC_BITS(REC_BITS), .NWORDS(NWORDS)) u_readout (
        .clk(clk), .rst(rst), .cap(cap), .rec_in(win), .held(rd_valid),
        .rd_req(rd_req), .rd_data(rd_data), .rd_last(rd_last), .rd_done(rd_done)
    );
endmodule

// File: rtl/xhc_checker.sv
module xhc_checker (
    input logic        clk,
    input logic        rst,
    input logic        tick,
    input logic        rd_req,
    input logic [15:0] rd_data,
    input logic        rd_valid,
    input logic        rd_last,
    input logic        rd_overrun
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!rd_valid && !rd_overrun && !rd_last)); // R1

    AST_FREEZE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid) |-> $past(tick)); // R2

    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_req) |=> (rd_valid && $stable(rd_data))); // R6

    AST_FINAL_READ_DROPS: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_req && rd_last) |=> !rd_valid); // R6

    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        rd_last |-> rd_valid); // R6

    AST_OVERRUN_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        rd_overrun |-> $past(tick)); // R7

    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (rd_data == 16'h0)); // R8
endmodule

bind xing_history_capture xhc_checker u_chk (
    .clk(clk), .rst(rst), .tick(tick), .rd_req(rd_req), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_last(rd_last), .rd_overrun(rd_overrun)
);

// File: tb/xing_history_capture_test.sv
`timescale 1ns/1ps
module xing_history_capture_test;
    localparam int NB = 4, PV = 1, NX = 2, LT = 2;
    localparam int W  = PV + 1 + NX;
    localparam int NW = (W * NB + 15) / 16;

    logic clk = 1'b0, rst = 1'b1, tick = 1'b0, accept = 1'b0, rd_req = 1'b0;
    logic [NB-1:0] state_in = '0;
    logic [15:0]   rd_data;
    logic          rd_valid, rd_last, rd_overrun;

    int n_cmp = 0, n_bad = 0, ovr_seen = 0;

    // behavioural model state
    logic [NB-1:0]   sq[$];
    int              aq[$];
    int              tk = 0, mst = 0, trig = 0, midx = 0;
    logic [NW*16-1:0] mrec = '0;
    logic            movr = 1'b0;

    always #2.5 clk = ~clk;

    xing_history_capture #(.NBITS(NB), .PREV(PV), .NEXT(NX), .LAT(LT)) uut (
        .clk(clk), .rst(rst), .tick(tick), .state_in(state_in), .accept(accept),
        .rd_req(rd_req), .rd_data(rd_data), .rd_valid(rd_valid),
        .rd_last(rd_last), .rd_overrun(rd_overrun)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [NB-1:0] hist_at(input int c);
        if (c < 0 || c >= sq.size()) return '0;
        return sq[c];
    endfunction

    task automatic model_capture(input int c);
        mrec = '0;
        for (int j = 0; j < W; j++) mrec[j*NB +: NB] = hist_at(c - PV + j);
        midx = 0;
    endtask

    task automatic model_step(input logic t, input logic [NB-1:0] s,
                              input logic a, input logic r);
        int  nst;
        logic accd;
        nst  = mst;
        movr = 1'b0;
        if (mst == 2 && r) begin
            if (midx == NW - 1) begin nst = 0; midx = 0; end
            else midx++;
        end
        if (t) begin
            sq.push_back(s);
            if (a) aq.push_back(tk);
            accd = (aq.size() > 0 && aq[0] == tk - LT);
            if (accd) void'(aq.pop_front());
            if (accd && mst != 0) movr = 1'b1;
            if (accd && mst == 0) begin
                if (NX == 0) begin model_capture(tk - LT); nst = 2; end
                else begin nst = 1; trig = tk - LT; end
            end
            if (mst == 1 && tk - LT == trig + NX) begin
                model_capture(trig); nst = 2;
            end
            tk++;
        end
        mst = nst;
    endtask

    task automatic compare();
        logic ev, el;
        logic [15:0] ed;
        ev = (mst == 2);
        ed = ev ? mrec[midx*16 +: 16] : 16'h0;
        el = ev && (midx == NW - 1);
        if (rd_overrun) ovr_seen++;
        check("R3 rd_valid", int'(rd_valid), int'(ev));
        check(ev ? "R4/R5 rd_data" : "R8 rd_data", int'(rd_data), int'(ed));
        check("R6 rd_last", int'(rd_last), int'(el));
        check("R7 rd_overrun", int'(rd_overrun), int'(movr));
    endtask

    task automatic cyc(input logic t, input logic [NB-1:0] s,
                       input logic a, input logic r);
        compare();
        tick = t; state_in = s; accept = a; rd_req = r;
        model_step(t, s, a, r);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL R3 watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset rd_valid", int'(rd_valid), 0);
        check("R1 reset rd_data", int'(rd_data), 0);
        check("R1 reset rd_overrun", int'(rd_overrun), 0);
        rst = 1'b0;

        // early accept at crossing 0; window crossings -1..2 -> 0,1,2,3
        for (int k = 0; k < 4; k++) cyc(1'b1, NB'(k + 1), k == 0, 1'b0);
        check("R3 not yet frozen", int'(rd_valid), 0);
        cyc(1'b1, NB'(5), 1'b0, 1'b0);
        check("R3 frozen after LAT+NEXT ticks", int'(rd_valid), 1);
        check("R5 packing oldest low", int'(rd_data), 16'h3210);
        check("R6 single word is last", int'(rd_last), 1);
        cyc(1'b0, '0, 1'b0, 1'b1);
        check("R6 read drops valid", int'(rd_valid), 0);

        // accept without tick must be ignored
        cyc(1'b0, 4'hF, 1'b1, 1'b0);
        for (int k = 0; k < 10; k++) cyc(1'b1, NB'(k), 1'b0, 1'b1);
        check("R2 no window without tick", int'(rd_valid), 0);

        // sparse ticks, back-to-back accepts, accept while held
        ovr_seen = 0;
        for (int k = 0; k < 14; k++) begin
            cyc(1'b1, NB'(k * 3 + 1), (k == 2 || k == 3 || k == 10), 1'b0);
            cyc(1'b0, 4'hA, 1'b0, 1'b0);
            cyc(1'b0, 4'h5, 1'b0, 1'b0);
        end
        check("R7 overrun pulses", ovr_seen, 2);
        check("R7 window still held", int'(rd_valid), 1);
        cyc(1'b0, '0, 1'b0, 1'b1);
        check("R6 released after read", int'(rd_valid), 0);

        // random traffic
        for (int k = 0; k < 3000; k++)
            cyc($urandom_range(1) == 1, NB'($urandom_range(15)),
                $urandom_range(15) == 0, $urandom_range(7) == 0);
        compare();

        summary();
        $finish;
    end
endmodule